// File: doc/BRIEF.md
# SD/MMC Data FIFO with Threshold Requests

This block is the data buffer between a processor and the transfer sequencer of an SD/MMC host. It is a circular store of 32 sixteen-bit words, tracked by a head pointer and an occupancy count. The processor pushes words on writes and pops them on reads. The card-side sequencer pushes and pops words through a second pair of strobes. Any pop returns the head word on a shared read-data output one cycle later.

The occupancy is compared against two programmable levels: a high-water mark for receive and a low-water mark for transmit. A per-direction enable steers each comparison result to one of two places: a DMA request line, or a status flag that software polls. Both places are held quiet while no transfer is running and the buffer is empty.

Top module: `sdfifo_thresh_ctrl`

## Requirements
- R1: After reset the level is 0, the high-water mark is 31, the low-water mark is 0, both DMA enables are off, and all four request/flag outputs are low. As a result, 31 stored words do not trip the receive comparison, and an empty buffer does not trip the transmit comparison.
- R2: Words leave in the order they entered, including when the head pointer wraps from slot 31 to slot 0. `rd_data` shows the popped word in the cycle after the pop strobe.
- R3: A push while 32 words are held and no pop is accepted is dropped. The level stays 32 and the stored words are unchanged.
- R4: A pop while the buffer is empty leaves the level at 0. `rd_data` then shows the word in the slot under the head pointer.
- R5: A push and an accepted pop in the same cycle leave the level unchanged, including at 32.
- R6: With the direction input at receive (`xfer_rx`=1), a level strictly above the high-water mark raises `rx_dma_req` if receive DMA is enabled, and raises `rx_flag` otherwise.
- R7: With the direction input at transmit (`xfer_rx`=0), a level strictly below the low-water mark raises `tx_dma_req` if transmit DMA is enabled, and raises `tx_flag` otherwise.
- R8: When a direction's comparison is false, or the other direction is selected, that direction's request and flag are both low.
- R9: With `xfer_active` low and the level at 0, all four request/flag outputs are low, whatever the configuration.
- R10: The configuration word holds four fields. Bit 15 is the receive DMA enable and bit 7 is the transmit DMA enable. Bits 12:8 are the high-water mark and bits 4:0 are the low-water mark. Writing a word with an enable set clears that direction's flag from the next cycle on.
- R11: When `cpu_wr` and `card_push` are both high in one cycle, only the processor word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration word |
| cpu_wr | input | 1 | Processor push strobe |
| cpu_wdata | input | 16 | Processor push data |
| cpu_rd | input | 1 | Processor pop strobe |
| card_push | input | 1 | Sequencer push strobe |
| card_wdata | input | 16 | Sequencer push data |
| card_pop | input | 1 | Sequencer pop strobe |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_rx | input | 1 | Transfer direction, 1 = receive from card |
| rd_data | output | 16 | Word at the head, registered one cycle after a pop |
| level | output | 6 | Current number of stored words |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_flag | output | 1 | Receive high-water status flag |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_flag | output | 1 | Transmit low-water status flag |

## Verification
The assertions hold the following every cycle:
- the count never passes 32;
- refused pushes and pops leave the level alone;
- a push paired with a pop keeps the level;
- the four request/flag outputs are at most one-hot and match the selected direction;
- the idle-and-empty condition silences everything;
- an enable write clears the matching flag.

Data ordering across the wrap, the stale word returned by an empty pop, the reset values of the marks, the field positions of the configuration word and the processor's priority over the sequencer can only be shown by the bench's scenarios. Each of these needs a known sequence of stored words.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
  // Configuration word layout; neighbours software and DMA setup decode these.
  localparam int CFG_W      = 16;
  localparam int RXDMA_BIT  = 15;
  localparam int HIWM_LSB   = 8;
  localparam int TXDMA_BIT  = 7;
  localparam int LOWM_LSB   = 0;

  typedef struct packed {
    logic rx_dma;
    logic tx_dma;
  } dma_en_t;
endpackage

// File: rtl/sdf_ring.sv
module sdf_ring #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [AW:0]   count_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] head_q;
  logic [AW:0]   cnt_q;
  logic [DW-1:0] rd_q;
  logic          full, empty, push_ok, pop_ok;
  logic [AW-1:0] tail;

  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign pop_ok  = pop_i && !empty;
  assign push_ok = push_i && (!full || pop_ok);
  assign tail    = head_q + cnt_q[AW-1:0];

  // Plain synchronous write port, read-first registered read: block RAM shape.
  always_ff @(posedge clk) begin
    if (push_ok) mem[tail] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    rd_q <= mem[head_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_ok) head_q <= head_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end

  assign rdata_o = rd_q;
  assign count_o = cnt_q;

  // R3: occupancy is bounded by the storage size
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= (AW+1)'(DEPTH));
  // R3: a push into a full buffer without a pop is dropped
  p_full_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (full && push_i && !pop_i) |=> (cnt_q == (AW+1)'(DEPTH)));
  // R4: a pop from an empty buffer changes nothing
  p_empty_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (empty && pop_i && !push_i) |=> (cnt_q == '0 && $stable(head_q)));
  // R5: paired push and accepted pop keep the level
  p_pair_level_r5: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && !empty) |=> $stable(cnt_q));
endmodule

// File: rtl/sdf_thresh.sv
module sdf_thresh
  import sdf_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW:0]   count_i,
  input  logic [AW-1:0] hiwm_i,
  input  logic [AW-1:0] lowm_i,
  input  dma_en_t       dma_en_i,
  input  logic          active_i,
  input  logic          dir_rx_i,
  output logic          rx_req_o,
  output logic          rx_flag_o,
  output logic          tx_req_o,
  output logic          tx_flag_o
);
  logic idle, rx_hit, tx_hit;

  assign idle   = !active_i && (count_i == '0);
  assign rx_hit = !idle &&  dir_rx_i && (count_i > {1'b0, hiwm_i});
  assign tx_hit = !idle && !dir_rx_i && (count_i < {1'b0, lowm_i});

  // Steering: each hit goes to exactly one of request or flag.
  assign rx_req_o  = rx_hit &&  dma_en_i.rx_dma;
  assign rx_flag_o = rx_hit && !dma_en_i.rx_dma;
  assign tx_req_o  = tx_hit &&  dma_en_i.tx_dma;
  assign tx_flag_o = tx_hit && !dma_en_i.tx_dma;

  // R6/R7: at most one of the four indications is active
  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rx_req_o, rx_flag_o, tx_req_o, tx_flag_o}));
  // R8: receive indications only in receive direction
  p_rx_dir_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_req_o || rx_flag_o) |-> dir_rx_i);
  // R8: transmit indications only in transmit direction
  p_tx_dir_r8: assert property (@(posedge clk) disable iff (rst)
    (tx_req_o || tx_flag_o) |-> !dir_rx_i);
endmodule

// File: rtl/sdfifo_thresh_ctrl.sv
module sdfifo_thresh_ctrl
  import sdf_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rd,
  input  logic          card_push,
  input  logic [DW-1:0] card_wdata,
  input  logic          card_pop,
  input  logic          xfer_active,
  input  logic          xfer_rx,
  output logic [DW-1:0] rd_data,
  output logic [AW:0]   level,
  output logic          rx_dma_req,
  output logic          rx_flag,
  output logic          tx_dma_req,
  output logic          tx_flag
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] hiwm_q, lowm_q;
  dma_en_t       dma_q;
  logic          push, pop;
  logic [DW-1:0] push_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiwm_q <= AW'(DEPTH - 1);
      lowm_q <= '0;
      dma_q  <= '0;
    end else if (cfg_we) begin
      hiwm_q        <= cfg_wdata[HIWM_LSB +: AW];
      lowm_q        <= cfg_wdata[LOWM_LSB +: AW];
      dma_q.rx_dma  <= cfg_wdata[RXDMA_BIT];
      dma_q.tx_dma  <= cfg_wdata[TXDMA_BIT];
    end
  end

  // Processor wins when both sides push in one cycle.
  assign push      = cpu_wr || card_push;
  assign push_data = cpu_wr ? cpu_wdata : card_wdata;
  assign pop       = cpu_rd || card_pop;

  sdf_ring #(.DW(DW), .AW(AW)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .push_i  (push),
    .wdata_i (push_data),
    .pop_i   (pop),
    .rdata_o (rd_data),
    .count_o (level)
  );

  sdf_thresh #(.AW(AW)) u_thresh (
    .clk       (clk),
    .rst       (rst),
    .count_i   (level),
    .hiwm_i    (hiwm_q),
    .lowm_i    (lowm_q),
    .dma_en_i  (dma_q),
    .active_i  (xfer_active),
    .dir_rx_i  (xfer_rx),
    .rx_req_o  (rx_dma_req),
    .rx_flag_o (rx_flag),
    .tx_req_o  (tx_dma_req),
    .tx_flag_o (tx_flag)
  );

  // R9: idle and empty silences every indication
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (!xfer_active && level == '0) |->
      !(rx_dma_req || rx_flag || tx_dma_req || tx_flag));
  // R10: enabling receive DMA clears the receive flag
  p_rx_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_wdata[RXDMA_BIT]) |=> !rx_flag);
  // R10: enabling transmit DMA clears the transmit flag
  p_tx_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_wdata[TXDMA_BIT]) |=> !tx_flag);
endmodule

// File: tb/sim_sdfifo_thresh_ctrl.sv
`timescale 1ns/1ps
module sim_sdfifo_thresh_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 0, cpu_wr = 0, cpu_rd = 0, card_push = 0, card_pop = 0;
  logic [15:0] cfg_wdata = 0, cpu_wdata = 0, card_wdata = 0;
  logic        xfer_active = 0, xfer_rx = 0;
  logic [15:0] rd_data;
  logic [5:0]  level;
  logic        rx_dma_req, rx_flag, tx_dma_req, tx_flag;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sdfifo_thresh_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
    .xfer_active(xfer_active), .xfer_rx(xfer_rx), .rd_data(rd_data),
    .level(level), .rx_dma_req(rx_dma_req), .rx_flag(rx_flag),
    .tx_dma_req(tx_dma_req), .tx_flag(tx_flag)
  );

  // Vector: op[31:30] (0 idle,1 cfg,2 push,3 pop) act[29] rx[28]
  // expected {rx_req,rx_flag,tx_req,tx_flag}[27:24] level[21:16] data[15:0]
  localparam int NV = 17;
  localparam logic [31:0] VEC [NV] = '{
    {2'd1, 1'b1, 1'b1, 4'b0000, 2'b00, 6'd0, 16'h0200}, // R10 hiwm=2
    {2'd2, 1'b1, 1'b1, 4'b0000, 2'b00, 6'd1, 16'h1001},
    {2'd2, 1'b1, 1'b1, 4'b0000, 2'b00, 6'd2, 16'h1002}, // R8 2 not above 2
    {2'd2, 1'b1, 1'b1, 4'b0100, 2'b00, 6'd3, 16'h1003}, // R6 flag
    {2'd1, 1'b1, 1'b1, 4'b1000, 2'b00, 6'd3, 16'h8200}, // R6/R10 dma clears flag
    {2'd3, 1'b1, 1'b1, 4'b0000, 2'b00, 6'd2, 16'h0000}, // R8
    {2'd1, 1'b1, 1'b0, 4'b0001, 2'b00, 6'd2, 16'h0004}, // R7 lowm=4 flag
    {2'd1, 1'b1, 1'b0, 4'b0010, 2'b00, 6'd2, 16'h0084}, // R7/R10 bit 7
    {2'd2, 1'b1, 1'b0, 4'b0010, 2'b00, 6'd3, 16'h1004},
    {2'd2, 1'b1, 1'b0, 4'b0000, 2'b00, 6'd4, 16'h1005}, // R8 4 not below 4
    {2'd0, 1'b1, 1'b1, 4'b0100, 2'b00, 6'd4, 16'h0000}, // R6 hiwm=0, R8 tx off
    {2'd3, 1'b0, 1'b0, 4'b0010, 2'b00, 6'd3, 16'h0000},
    {2'd3, 1'b0, 1'b0, 4'b0010, 2'b00, 6'd2, 16'h0000},
    {2'd3, 1'b0, 1'b0, 4'b0010, 2'b00, 6'd1, 16'h0000},
    {2'd3, 1'b0, 1'b0, 4'b0000, 2'b00, 6'd0, 16'h0000}, // R9 idle empty
    {2'd0, 1'b1, 1'b0, 4'b0010, 2'b00, 6'd0, 16'h0000}, // R7 active empty
    {2'd0, 1'b0, 1'b1, 4'b0000, 2'b00, 6'd0, 16'h0000}  // R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {28'd0, rx_dma_req, rx_flag, tx_dma_req, tx_flag};
  endfunction

  // One strobe cycle; returns at the following falling edge.
  task automatic cyc(input logic wr, input logic rd, input logic cp, input logic cq,
                     input logic cw, input logic [15:0] d, input logic [15:0] cd);
    @(negedge clk);
    cpu_wr = wr; cpu_rd = rd; card_push = cp; card_pop = cq; cfg_we = cw;
    cpu_wdata = d; cfg_wdata = d; card_wdata = cd;
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 0; cpu_rd = 0; card_push = 0; card_pop = 0; cfg_we = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state; empty transmit with lowm 0 stays quiet
    xfer_active = 1; xfer_rx = 0;
    @(negedge clk);
    chk("R1 level", 32'(level), 0);
    chk("R1 outs", outs(), 0);

    // R1/R6 fill to 31 with hiwm 31: quiet; 32: receive flag
    xfer_rx = 1;
    for (int i = 0; i < 32; i++) begin
      cyc(1, 0, 0, 0, 0, 16'hA000 + 16'(i), 0);
      if (i == 30) chk("R1 hiwm31 at 31", outs(), 0);
    end
    chk("R6 full flag", outs(), 32'b0100);
    // R3 push into full is dropped
    cyc(1, 0, 0, 0, 0, 16'hBEEF, 0);
    chk("R3 level", 32'(level), 32);
    // R2 order out; R3 contents intact
    for (int i = 0; i < 32; i++) begin
      cyc(0, 1, 0, 0, 0, 0, 0);
      chk("R2 order", 32'(rd_data), 32'(16'hA000 + 16'(i)));
    end
    chk("R3 level after drain", 32'(level), 0);
    // R4 empty pop: level stays, head slot word shown
    cyc(0, 1, 0, 0, 0, 0, 0);
    chk("R4 level", 32'(level), 0);
    chk("R4 stale head", 32'(rd_data), 32'h0000A000);

    // R2 wrap: move head to 20, fill across the wrap
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 0, 16'hC000 + 16'(i), 0);
    for (int i = 0; i < 20; i++) begin
      cyc(0, 0, 0, 1, 0, 0, 0);
      chk("R2 card pop order", 32'(rd_data), 32'(16'hC000 + 16'(i)));
    end
    for (int i = 0; i < 32; i++) cyc(1, 0, 0, 0, 0, 16'hD000 + 16'(i), 0);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 1, 0, 0, 0, 0, 0);
      chk("R2 wrap order", 32'(rd_data), 32'(16'hD000 + 16'(i)));
    end
    // R5 push plus pop keeps level 27
    cyc(1, 0, 0, 1, 0, 16'hE000, 0);
    chk("R5 level", 32'(level), 27);
    chk("R5 popped", 32'(rd_data), 32'h0000D005);
    for (int i = 1; i < 6; i++) cyc(1, 0, 0, 0, 0, 16'hE000 + 16'(i), 0);
    chk("R5 refill", 32'(level), 32);
    // R5 at full
    cyc(1, 1, 0, 0, 0, 16'hE006, 0);
    chk("R5 full level", 32'(level), 32);
    chk("R5 full popped", 32'(rd_data), 32'h0000D006);
    for (int i = 0; i < 32; i++) begin
      logic [15:0] e;
      e = (i < 25) ? 16'hD007 + 16'(i) : 16'hE000 + 16'(i - 25);
      cyc(0, 1, 0, 0, 0, 0, 0);
      chk("R2 wrap drain", 32'(rd_data), 32'(e));
    end

    // R11 processor has priority over sequencer
    cyc(1, 0, 1, 0, 0, 16'hF00F, 16'h0BAD);
    chk("R11 level", 32'(level), 1);
    cyc(0, 1, 0, 0, 0, 0, 0);
    chk("R11 data", 32'(rd_data), 32'h0000F00F);
    chk("R11 empty", 32'(level), 0);

    // Threshold table, from a fresh reset
    do_reset();
    for (int v = 0; v < NV; v++) begin
      logic [31:0] w;
      w = VEC[v];
      xfer_active = w[29]; xfer_rx = w[28];
      case (w[31:30])
        2'd1: cyc(0, 0, 0, 0, 1, w[15:0], 0);
        2'd2: cyc(1, 0, 0, 0, 0, w[15:0], 0);
        2'd3: cyc(0, 1, 0, 0, 0, 0, 0);
        default: cyc(0, 0, 0, 0, 0, 0, 0);
      endcase
      chk($sformatf("R6-R10 vec%0d level", v), 32'(level), 32'(w[21:16]));
      chk($sformatf("R6-R10 vec%0d outs", v), outs(), 32'(w[27:24]));
    end

    // R9 idle-empty quiet even with lowm above zero and no DMA
    cyc(0, 0, 0, 0, 1, 16'h001F, 0);
    xfer_active = 0; xfer_rx = 0;
    @(negedge clk);
    chk("R9 idle quiet", outs(), 0);
    xfer_active = 1;
    @(negedge clk);
    chk("R7 active flag", outs(), 32'b0001);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule